// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block forms the memory address for an operand access in a 16-bit processor with segmented memory. The execution stage supplies the pointer registers (two base registers BX and BP, two index registers SI and DI) and the four segment registers, together with a decoded description of the operand's address form. That description gives the base choice, the index choice, the displacement size and value, an optional segment-override request, and a flag that marks a string-destination access. The block adds the selected parts into a 16-bit effective offset. It picks the segment that the access uses and produces the 20-bit physical address from the segment and the offset.

The arithmetic is combinational. The results are captured in an output register when a request is presented, so each answer appears one clock after its request and then holds until the next request. The supported forms are direct (displacement only), register indirect, based, indexed and based-indexed, each with no displacement, a short 8-bit displacement or a full 16-bit displacement.

Top module: `seg_ea_gen`

## Requirements
- R1: While rst_ni is low, and after reset until the first request, valid_o, offset_o, seg_id_o, seg_val_o and paddr_o are all zero.
- R2: valid_o is high in the cycle after a cycle with req_i high and low otherwise. The other outputs change only in the cycle after a request and hold their values when req_i is low.
- R3: When str_dst_i is low, offset_o = (base + index + displacement) mod 65536. The base is taken from base_sel_i (0 none, 1 BX, 2 BP, 3 none), the index from idx_sel_i (0 none, 1 SI, 2 DI, 3 none), and the displacement from disp_size_i (0 none, 1 short, 2 full 16-bit disp_i, 3 none).
- R4: A short displacement uses only disp_i[7:0], sign-extended to 16 bits. disp_i[15:8] has no effect in that case.
- R5: Without override and without string destination, an access with BP as its base uses SS (seg_id_o = 2). Every other access uses DS (seg_id_o = 3).
- R6: When ovr_en_i is high and str_dst_i is low, the segment code ovr_seg_i (0 ES, 1 CS, 2 SS, 3 DS) replaces the default segment. This includes string-source accesses through SI.
- R7: When str_dst_i is high, offset_o = DI and seg_id_o = 0 (ES). base_sel_i, idx_sel_i, the displacement and the override have no effect.
- R8: paddr_o = (seg_val_o * 16 + offset_o) mod 2^20.
- R9: seg_val_o is the value of the segment register named by seg_id_o at the time of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Compute and capture an address this cycle |
| bx_i | input | 16 | Base register BX |
| bp_i | input | 16 | Base register BP |
| si_i | input | 16 | Index register SI |
| di_i | input | 16 | Index register DI |
| cs_i | input | 16 | Code segment register |
| ss_i | input | 16 | Stack segment register |
| ds_i | input | 16 | Data segment register |
| es_i | input | 16 | Extra segment register |
| base_sel_i | input | 2 | Base choice: 0 none, 1 BX, 2 BP |
| idx_sel_i | input | 2 | Index choice: 0 none, 1 SI, 2 DI |
| disp_size_i | input | 2 | Displacement: 0 none, 1 short, 2 full |
| disp_i | input | 16 | Displacement value |
| ovr_en_i | input | 1 | Segment override requested |
| ovr_seg_i | input | 2 | Override segment code: 0 ES, 1 CS, 2 SS, 3 DS |
| str_dst_i | input | 1 | String-destination access |
| valid_o | output | 1 | Result registered from the previous cycle's request |
| offset_o | output | 16 | Effective offset |
| seg_id_o | output | 2 | Selected segment code |
| seg_val_o | output | 16 | Selected segment register value |
| paddr_o | output | 20 | Physical address |

## Verification
The bench targets several corner cases:
- A negative short displacement. A design that zero-extends it would point 256 bytes too high.
- An offset sum that crosses 0xFFFF. If the carry leaks into the 20-bit add, the address lands 64 KB off.
- A segment near the top of memory. Here the physical sum must wrap instead of spilling into a 21st bit.
- An override paired with a string destination and a BP base. A design that lets the override win, or that keeps the BP default, sends a string store to the wrong segment.
- Idle cycles. If the outputs drift while no request is present, consumers latch stale or wrong addresses.

// File: rtl/seg_ea_pkg.sv
package seg_ea_pkg;
  typedef enum logic [1:0] {SEG_ES = 2'd0, SEG_CS = 2'd1, SEG_SS = 2'd2, SEG_DS = 2'd3} seg_id_e;
  typedef enum logic [1:0] {BASE_NONE = 2'd0, BASE_BX = 2'd1, BASE_BP = 2'd2, BASE_RSV = 2'd3} base_sel_e;
  typedef enum logic [1:0] {IDX_NONE = 2'd0, IDX_SI = 2'd1, IDX_DI = 2'd2, IDX_RSV = 2'd3} idx_sel_e;
  typedef enum logic [1:0] {DISP_NONE = 2'd0, DISP_SHORT = 2'd1, DISP_FULL = 2'd2, DISP_RSV = 2'd3} disp_size_e;
  localparam int unsigned NUM_SEG = 4;
endpackage

// File: rtl/seg_ea_offset.sv
module seg_ea_offset
  import seg_ea_pkg::*;
#(
  parameter int unsigned OFF_W        = 16,
  parameter int unsigned DISP_SHORT_W = 8
) (
  input  logic [OFF_W-1:0] bx_i,
  input  logic [OFF_W-1:0] bp_i,
  input  logic [OFF_W-1:0] si_i,
  input  logic [OFF_W-1:0] di_i,
  input  base_sel_e        base_sel_i,
  input  idx_sel_e         idx_sel_i,
  input  disp_size_e       disp_size_i,
  input  logic [OFF_W-1:0] disp_i,
  input  logic             str_dst_i,
  output logic [OFF_W-1:0] offset_o
);
  localparam int unsigned EXT_W = OFF_W - DISP_SHORT_W;

  logic [OFF_W-1:0] base_val, idx_val, disp_val;

  always_comb begin
    unique case (base_sel_i)
      BASE_BX: base_val = bx_i;
      BASE_BP: base_val = bp_i;
      default: base_val = '0;
    endcase
    unique case (idx_sel_i)
      IDX_SI:  idx_val = si_i;
      IDX_DI:  idx_val = di_i;
      default: idx_val = '0;
    endcase
    unique case (disp_size_i)
      DISP_SHORT: disp_val = {{EXT_W{disp_i[DISP_SHORT_W-1]}}, disp_i[DISP_SHORT_W-1:0]};
      DISP_FULL:  disp_val = disp_i;
      default:    disp_val = '0;
    endcase
  end

  // string destination addresses through DI alone
  assign offset_o = str_dst_i ? di_i : OFF_W'(base_val + idx_val + disp_val);
endmodule

// File: rtl/seg_ea_segsel.sv
module seg_ea_segsel
  import seg_ea_pkg::*;
#(
  parameter int unsigned SEG_W = 16
) (
  input  logic [SEG_W-1:0] cs_i,
  input  logic [SEG_W-1:0] ss_i,
  input  logic [SEG_W-1:0] ds_i,
  input  logic [SEG_W-1:0] es_i,
  input  base_sel_e        base_sel_i,
  input  logic             ovr_en_i,
  input  seg_id_e          ovr_seg_i,
  input  logic             str_dst_i,
  output seg_id_e          seg_id_o,
  output logic [SEG_W-1:0] seg_val_o
);
  logic [SEG_W-1:0] seg_bank [NUM_SEG];
  logic [SEG_W-1:0] seg_src  [NUM_SEG];

  assign seg_src[SEG_ES] = es_i;
  assign seg_src[SEG_CS] = cs_i;
  assign seg_src[SEG_SS] = ss_i;
  assign seg_src[SEG_DS] = ds_i;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_bank
    assign seg_bank[g] = seg_src[g];
  end

  // priority: string destination, then override, then base-derived default
  always_comb begin
    if (str_dst_i)                  seg_id_o = SEG_ES;
    else if (ovr_en_i)              seg_id_o = ovr_seg_i;
    else if (base_sel_i == BASE_BP) seg_id_o = SEG_SS;
    else                            seg_id_o = SEG_DS;
  end

  assign seg_val_o = seg_bank[seg_id_o];
endmodule

// File: rtl/seg_ea_phys.sv
module seg_ea_phys #(
  parameter int unsigned OFF_W     = 16,
  parameter int unsigned SEG_SHIFT = 4
) (
  input  logic [OFF_W-1:0]           seg_val_i,
  input  logic [OFF_W-1:0]           offset_i,
  output logic [OFF_W+SEG_SHIFT-1:0] paddr_o
);
  localparam int unsigned PA_W = OFF_W + SEG_SHIFT;

  logic [PA_W-1:0] seg_base;
  assign seg_base = {seg_val_i, {SEG_SHIFT{1'b0}}};
  assign paddr_o  = seg_base + PA_W'(offset_i);
endmodule

// File: rtl/seg_ea_gen.sv
module seg_ea_gen
  import seg_ea_pkg::*;
#(
  parameter int unsigned OFF_W        = 16,
  parameter int unsigned SEG_SHIFT    = 4,
  parameter int unsigned DISP_SHORT_W = 8,
  localparam int unsigned PA_W        = OFF_W + SEG_SHIFT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [OFF_W-1:0] bx_i,
  input  logic [OFF_W-1:0] bp_i,
  input  logic [OFF_W-1:0] si_i,
  input  logic [OFF_W-1:0] di_i,
  input  logic [OFF_W-1:0] cs_i,
  input  logic [OFF_W-1:0] ss_i,
  input  logic [OFF_W-1:0] ds_i,
  input  logic [OFF_W-1:0] es_i,
  input  logic [1:0]       base_sel_i,
  input  logic [1:0]       idx_sel_i,
  input  logic [1:0]       disp_size_i,
  input  logic [OFF_W-1:0] disp_i,
  input  logic             ovr_en_i,
  input  logic [1:0]       ovr_seg_i,
  input  logic             str_dst_i,
  output logic             valid_o,
  output logic [OFF_W-1:0] offset_o,
  output logic [1:0]       seg_id_o,
  output logic [OFF_W-1:0] seg_val_o,
  output logic [PA_W-1:0]  paddr_o
);
  logic [OFF_W-1:0] offset_d, seg_val_d;
  logic [PA_W-1:0]  paddr_d;
  seg_id_e          seg_id_d;

  seg_ea_offset #(.OFF_W(OFF_W), .DISP_SHORT_W(DISP_SHORT_W)) u_offset (
    .bx_i        (bx_i),
    .bp_i        (bp_i),
    .si_i        (si_i),
    .di_i        (di_i),
    .base_sel_i  (base_sel_e'(base_sel_i)),
    .idx_sel_i   (idx_sel_e'(idx_sel_i)),
    .disp_size_i (disp_size_e'(disp_size_i)),
    .disp_i      (disp_i),
    .str_dst_i   (str_dst_i),
    .offset_o    (offset_d)
  );

  seg_ea_segsel #(.SEG_W(OFF_W)) u_segsel (
    .cs_i       (cs_i),
    .ss_i       (ss_i),
    .ds_i       (ds_i),
    .es_i       (es_i),
    .base_sel_i (base_sel_e'(base_sel_i)),
    .ovr_en_i   (ovr_en_i),
    .ovr_seg_i  (seg_id_e'(ovr_seg_i)),
    .str_dst_i  (str_dst_i),
    .seg_id_o   (seg_id_d),
    .seg_val_o  (seg_val_d)
  );

  seg_ea_phys #(.OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT)) u_phys (
    .seg_val_i (seg_val_d),
    .offset_i  (offset_d),
    .paddr_o   (paddr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      offset_o  <= '0;
      seg_id_o  <= '0;
      seg_val_o <= '0;
      paddr_o   <= '0;
    end else begin
      valid_o <= req_i;
      if (req_i) begin
        offset_o  <= offset_d;
        seg_id_o  <= seg_id_d;
        seg_val_o <= seg_val_d;
        paddr_o   <= paddr_d;
      end
    end
  end
endmodule

// File: rtl/seg_ea_gen_chk.sv
module seg_ea_gen_chk #(
  parameter int unsigned OFF_W     = 16,
  parameter int unsigned SEG_SHIFT = 4,
  localparam int unsigned PA_W     = OFF_W + SEG_SHIFT
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             str_dst_i,
  input logic             ovr_en_i,
  input logic [1:0]       ovr_seg_i,
  input logic [1:0]       base_sel_i,
  input logic [OFF_W-1:0] di_i,
  input logic             valid_o,
  input logic [OFF_W-1:0] offset_o,
  input logic [1:0]       seg_id_o,
  input logic [OFF_W-1:0] seg_val_o,
  input logic [PA_W-1:0]  paddr_o
);
  logic [PA_W-1:0] exp_pa;
  assign exp_pa = {seg_val_o, {SEG_SHIFT{1'b0}}} + PA_W'(offset_o);

  a_r2_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni) req_i |=> valid_o);
  a_r2_valid_fall: assert property (@(posedge clk_i) disable iff (!rst_ni) !req_i |=> !valid_o);
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> ($stable(offset_o) && $stable(paddr_o) && $stable(seg_id_o) && $stable(seg_val_o)));
  a_r5_bp_stack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !str_dst_i && !ovr_en_i && base_sel_i == 2'd2) |=> seg_id_o == 2'd2);
  a_r6_override: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ovr_en_i && !str_dst_i) |=> seg_id_o == $past(ovr_seg_i));
  a_r7_str_dst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && str_dst_i) |=> (seg_id_o == 2'd0 && offset_o == $past(di_i)));
  a_r8_paddr: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_o |-> paddr_o == exp_pa);
endmodule

bind seg_ea_gen seg_ea_gen_chk #(.OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .str_dst_i  (str_dst_i),
  .ovr_en_i   (ovr_en_i),
  .ovr_seg_i  (ovr_seg_i),
  .base_sel_i (base_sel_i),
  .di_i       (di_i),
  .valid_o    (valid_o),
  .offset_o   (offset_o),
  .seg_id_o   (seg_id_o),
  .seg_val_o  (seg_val_o),
  .paddr_o    (paddr_o)
);

// File: tb/seg_ea_gen_tb_top.sv
module seg_ea_gen_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0;
  logic [15:0] bx_i = '0, bp_i = '0, si_i = '0, di_i = '0;
  logic [15:0] cs_i = '0, ss_i = '0, ds_i = '0, es_i = '0;
  logic [1:0] base_sel_i = '0, idx_sel_i = '0, disp_size_i = '0, ovr_seg_i = '0;
  logic [15:0] disp_i = '0;
  logic ovr_en_i = 1'b0, str_dst_i = 1'b0;
  logic valid_o;
  logic [15:0] offset_o, seg_val_o;
  logic [1:0] seg_id_o;
  logic [19:0] paddr_o;

  int checks = 0, failures = 0;
  bit done = 0;
  int e_valid = 0, e_off = 0, e_seg = 0, e_sval = 0, e_pa = 0;

  always #10 clk_i = ~clk_i;

  seg_ea_gen dut_i (.*);

  task automatic chk(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", rq, what, act, exp);
    end
  endtask

  function automatic int seg_of(input int code);
    case (code)
      0: return int'(es_i);
      1: return int'(cs_i);
      2: return int'(ss_i);
      default: return int'(ds_i);
    endcase
  endfunction

  // behavioural reference, evaluated on the inputs present at the request
  task automatic model();
    int b, x, d;
    b = (base_sel_i == 1) ? int'(bx_i) : (base_sel_i == 2) ? int'(bp_i) : 0;
    x = (idx_sel_i == 1) ? int'(si_i) : (idx_sel_i == 2) ? int'(di_i) : 0;
    if (disp_size_i == 1) d = (disp_i[7:0] >= 128) ? int'(disp_i[7:0]) - 256 : int'(disp_i[7:0]);
    else if (disp_size_i == 2) d = int'(disp_i);
    else d = 0;
    if (str_dst_i) begin
      e_off = int'(di_i); e_seg = 0;
    end else begin
      e_off = (b + x + d + 65536 * 4) % 65536;
      if (ovr_en_i) e_seg = int'(ovr_seg_i);
      else if (base_sel_i == 2) e_seg = 2;
      else e_seg = 3;
    end
    e_sval = seg_of(e_seg);
    e_pa = (e_sval * 16 + e_off) % (1 << 20);
  endtask

  task automatic step(input string rq);
    if (req_i) model();
    e_valid = int'(req_i);
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R2", "valid", int'(valid_o), e_valid);
    chk(rq, "offset", int'(offset_o), e_off);
    chk(rq, "seg_id", int'(seg_id_o), e_seg);
    chk("R9", "seg_val", int'(seg_val_o), e_sval);
    chk("R8", "paddr", int'(paddr_o), e_pa);
  endtask

  task automatic set_acc(input int bs, input int ix, input int ds, input int dv,
                         input bit oe, input int os, input bit sd);
    req_i = 1'b1;
    base_sel_i = 2'(bs); idx_sel_i = 2'(ix); disp_size_i = 2'(ds); disp_i = 16'(dv);
    ovr_en_i = oe; ovr_seg_i = 2'(os); str_dst_i = sd;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bx_i = 16'h1200; bp_i = 16'h3400; si_i = 16'h0056; di_i = 16'h0078;
    cs_i = 16'h1000; ss_i = 16'h2000; ds_i = 16'h3000; es_i = 16'h4000;
    repeat (3) @(negedge clk_i);
    // R1 during reset
    chk("R1", "valid", int'(valid_o), 0);
    chk("R1", "offset", int'(offset_o), 0);
    chk("R1", "paddr", int'(paddr_o), 0);
    chk("R1", "seg_id", int'(seg_id_o), 0);
    chk("R1", "seg_val", int'(seg_val_o), 0);
    rst_ni = 1'b1;
    step("R1");
    // R3 direct full displacement
    set_acc(0, 0, 2, 'h1234, 0, 0, 0); step("R3");
    // R3 based-indexed BX+SI with negative short disp, upper byte garbage (R4)
    set_acc(1, 1, 1, 'hABF0, 0, 0, 0); step("R4");
    // R5 BP+DI defaults to SS
    set_acc(2, 2, 0, 0, 0, 0, 0); step("R5");
    // R5 indexed SI defaults to DS
    set_acc(0, 1, 2, 'h0100, 0, 0, 0); step("R5");
    // R6 BP with DS override
    set_acc(2, 0, 1, 'h7F, 1, 3, 0); step("R6");
    // R6 string source via SI with ES override
    set_acc(0, 1, 0, 0, 1, 0, 0); step("R6");
    // R7 string destination ignores override and base
    set_acc(2, 1, 2, 'h5555, 1, 1, 1); step("R7");
    // R2 idle hold
    req_i = 1'b0; set_acc(1, 1, 2, 'hFFFF, 0, 0, 0); req_i = 1'b0; step("R2");
    step("R2");
    // R3 offset wrap
    bx_i = 16'hFFFF; set_acc(1, 0, 2, 2, 0, 0, 0); step("R3");
    // R8 physical wrap at top of memory
    ds_i = 16'hFFFF; bx_i = 16'hFFFF; set_acc(1, 0, 0, 0, 0, 0, 0); step("R8");
    // R4 sign extension of -1 on zero base
    set_acc(0, 0, 1, 'h00FF, 0, 1, 0); step("R4");
    // random patterns
    for (int i = 0; i < 400; i++) begin
      @(negedge clk_i);
      {bx_i, bp_i} = {16'($urandom), 16'($urandom)};
      {si_i, di_i} = {16'($urandom), 16'($urandom)};
      {cs_i, ss_i} = {16'($urandom), 16'($urandom)};
      {ds_i, es_i} = {16'($urandom), 16'($urandom)};
      set_acc(int'($urandom % 4), int'($urandom % 4), int'($urandom % 4), int'($urandom % 65536),
              1'($urandom), int'($urandom % 4), ($urandom % 5) == 0);
      req_i = ($urandom % 4) != 0;
      step("R3");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule